// File: doc/BRIEF.md
# Strided Interleaved Bank Address Generator

This block walks a vector memory access: given a base word address, a stride and an element count, it issues the address of element i as base + i*stride, one element per cycle at most and always in index order. The words are spread over sixteen interleaved banks, selected by the low bits of the word address. Each bank stays occupied for a few cycles after it takes a request. A per-bank scoreboard holds the next element in place until its bank is free again, so a bank never sees a request while it is occupied.

The memory beside the block answers in the cycle of the request on `mem_rdata`. The block carries that word through a fixed-latency return path together with the element index, so the consumer receives data tagged by element. A one-cycle `done` pulse marks the return of the last element. A vector of length zero produces `done` without issuing anything.

Top module: `vec_bank_agu`

## Requirements
- R1: Element i is issued with `req_addr` = base + i*stride (modulo 2^AW) and `req_idx` = i. Elements go out in strictly increasing index order 0..vlen-1, with at most one `req_valid` per cycle.
- R2: `req_bank` equals bits [3:0] of `req_addr` (16 banks).
- R3: After a bank takes a request in cycle t, it gets no further request before cycle t+4.
- R4: If the bank of the next element is occupied, issue stalls and address and index hold. With stride 1 the elements issue in consecutive cycles. With stride 8 the banks alternate 0/8 and the third element issues exactly 4 cycles after the first.
- R5: A stride that is a multiple of 16 sends every element to the same bank, at exactly one request every 4 cycles.
- R6: An element issued in cycle t appears in cycle t+12 with `rsp_valid`=1, `rsp_idx` = its index, and `rsp_data` = the `mem_rdata` value present in cycle t.
- R7: `done` is high for exactly one cycle per vector: the cycle in which the last element's response appears.
- R8: A start with vlen = 0 issues no request and raises `done` in the cycle after the start.
- R9: `start` is taken only while `busy` is low, and the operands are captured at that edge. The first request comes no earlier than the following cycle. A `start` while `busy` is high has no effect.
- R10: After reset `req_valid`, `rsp_valid`, `done` and `busy` are low, and every bank is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a vector access (taken when idle) |
| base_addr | input | AW | First element word address |
| stride | input | AW | Word distance between elements (two's complement wrap) |
| vlen | input | LW | Number of elements |
| busy | output | 1 | Issue or return still in progress |
| req_valid | output | 1 | Element request this cycle |
| req_addr | output | AW | Element word address |
| req_bank | output | 4 | Bank addressed |
| req_idx | output | LW | Element index of the request |
| mem_rdata | input | DW | Word read for `req_addr` in the same cycle |
| rsp_valid | output | 1 | Returned element |
| rsp_idx | output | LW | Index of the returned element |
| rsp_data | output | DW | Returned word |
| done | output | 1 | Last element returned (or empty vector) |

## Verification
On every cycle the assertions check four things: no request reaches a bank whose occupancy counter is still running, address and index freeze while stalled, the address steps by exactly the stride between consecutive issues, and an empty vector goes straight to done. Throughput under the different stride patterns, the exact 12-cycle return with the right index and data, the single done per vector, and the rejection of a start while busy all depend on whole sequences. The bench shows these by comparing against its cycle-level model.

// File: rtl/vagu_pkg.sv
package vagu_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/vagu_bank_board.sv
module vagu_bank_board #(
  parameter int NBANK = 16,
  parameter int BUSY  = 4,
  parameter int BW    = $clog2(NBANK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic [BW-1:0]    issue_bank,
  output logic [NBANK-1:0] bank_ready
);
  localparam int CW = $clog2(BUSY + 1);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [CW-1:0] cnt_q, cnt_d;
    logic          hit, cnt_en;

    assign hit    = issue && (issue_bank == BW'(b));
    assign cnt_en = hit || (cnt_q != '0);

    always_comb begin
      cnt_d = cnt_q;
      if (hit)               cnt_d = CW'(BUSY - 1);
      else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (cnt_en) cnt_q <= cnt_d;
    end

    assign bank_ready[b] = (cnt_q == '0);

    // R3: a request only reaches a bank whose occupancy has run out
    assert_busy_bank_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> (cnt_q == '0));
  end
endmodule

// File: rtl/vagu_issue_seq.sv
module vagu_issue_seq
  import vagu_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LW    = 8,
  parameter int NBANK = 16,
  parameter int BW    = $clog2(NBANK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    base_addr,
  input  logic [AW-1:0]    stride,
  input  logic [LW-1:0]    vlen,
  input  logic [NBANK-1:0] bank_ready,
  input  logic             inflight,
  output logic             issue,
  output logic [AW-1:0]    issue_addr,
  output logic [BW-1:0]    issue_bank,
  output logic [LW-1:0]    issue_idx,
  output logic             issue_last,
  output logic             zero_done,
  output logic             busy
);
  seq_state_e    state_q, state_d;
  logic [AW-1:0] addr_q, addr_d, stride_q;
  logic [LW-1:0] idx_q, idx_d, vlen_q;
  logic          zdone_q, zdone_d;
  logic          accept, op_en;

  assign accept     = start && (state_q == SEQ_IDLE) && !inflight;
  assign issue_bank = addr_q[BW-1:0];
  assign issue      = (state_q == SEQ_RUN) && bank_ready[issue_bank];
  assign issue_last = (idx_q == vlen_q - 1'b1);
  assign op_en      = accept || issue;

  always_comb begin
    state_d = state_q;
    if (accept && (vlen != '0)) state_d = SEQ_RUN;
    if (issue && issue_last)    state_d = SEQ_IDLE;
    addr_d  = accept ? base_addr : addr_q + stride_q;
    idx_d   = accept ? '0 : idx_q + 1'b1;
    zdone_d = accept && (vlen == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      zdone_q <= 1'b0;
    end else begin
      state_q <= state_d;
      zdone_q <= zdone_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      idx_q  <= '0;
    end else if (op_en) begin
      addr_q <= addr_d;
      idx_q  <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stride_q <= '0;
      vlen_q   <= '0;
    end else if (accept) begin
      stride_q <= stride;
      vlen_q   <= vlen;
    end
  end

  assign issue_addr = addr_q;
  assign issue_idx  = idx_q;
  assign zero_done  = zdone_q;
  assign busy       = (state_q == SEQ_RUN) || inflight;

  // R4: a stalled element keeps its address and index
  assert_stall_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == SEQ_RUN) && !issue) |=> ($stable(addr_q) && $stable(idx_q)));

  // R1: consecutive issues of one vector step by the stride and by one index
  assert_addr_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !issue_last) |=> ((addr_q == $past(addr_q) + $past(stride_q)) &&
                                (idx_q == $past(idx_q) + 1'b1)));

  // R8: an empty vector never enters the issuing state
  assert_zero_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (vlen == '0)) |=> ((state_q == SEQ_IDLE) && zero_done));
endmodule

// File: rtl/vagu_ret_pipe.sv
module vagu_ret_pipe #(
  parameter int LW  = 8,
  parameter int DW  = 32,
  parameter int LAT = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [LW-1:0] in_idx,
  input  logic [DW-1:0] in_data,
  input  logic          in_last,
  output logic          out_valid,
  output logic [LW-1:0] out_idx,
  output logic [DW-1:0] out_data,
  output logic          out_last,
  output logic          inflight
);
  logic [LAT-1:0] v_q;
  logic [LW-1:0]  i_q [LAT];
  logic [DW-1:0]  d_q [LAT];
  logic [LAT-1:0] l_q;

  for (genvar s = 0; s < LAT; s++) begin : g_stage
    logic          src_v, src_l;
    logic [LW-1:0] src_i;
    logic [DW-1:0] src_d;

    if (s == 0) begin : g_head
      assign src_v = in_valid;
      assign src_i = in_idx;
      assign src_d = in_data;
      assign src_l = in_last;
    end else begin : g_body
      assign src_v = v_q[s-1];
      assign src_i = i_q[s-1];
      assign src_d = d_q[s-1];
      assign src_l = l_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q[s] <= 1'b0;
      else        v_q[s] <= src_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        i_q[s] <= '0;
        d_q[s] <= '0;
        l_q[s] <= 1'b0;
      end else if (src_v) begin
        i_q[s] <= src_i;
        d_q[s] <= src_d;
        l_q[s] <= src_l;
      end
    end
  end

  assign out_valid = v_q[LAT-1];
  assign out_idx   = i_q[LAT-1];
  assign out_data  = d_q[LAT-1];
  assign out_last  = v_q[LAT-1] && l_q[LAT-1];
  assign inflight  = |v_q;
endmodule

// File: rtl/vec_bank_agu.sv
module vec_bank_agu #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int LW    = 8,
  parameter int NBANK = 16,
  parameter int BUSY  = 4,
  parameter int LAT   = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [AW-1:0]            base_addr,
  input  logic [AW-1:0]            stride,
  input  logic [LW-1:0]            vlen,
  output logic                     busy,
  output logic                     req_valid,
  output logic [AW-1:0]            req_addr,
  output logic [$clog2(NBANK)-1:0] req_bank,
  output logic [LW-1:0]            req_idx,
  input  logic [DW-1:0]            mem_rdata,
  output logic                     rsp_valid,
  output logic [LW-1:0]            rsp_idx,
  output logic [DW-1:0]            rsp_data,
  output logic                     done
);
  localparam int BW = $clog2(NBANK);

  logic [NBANK-1:0] bank_ready;
  logic             issue, issue_last, zero_done, inflight, ret_last;
  logic [AW-1:0]    issue_addr;
  logic [BW-1:0]    issue_bank;
  logic [LW-1:0]    issue_idx;

  vagu_issue_seq #(.AW(AW), .LW(LW), .NBANK(NBANK), .BW(BW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .stride(stride), .vlen(vlen), .bank_ready(bank_ready), .inflight(inflight),
    .issue(issue), .issue_addr(issue_addr), .issue_bank(issue_bank),
    .issue_idx(issue_idx), .issue_last(issue_last), .zero_done(zero_done),
    .busy(busy));

  vagu_bank_board #(.NBANK(NBANK), .BUSY(BUSY), .BW(BW)) u_board (
    .clk(clk), .rst_n(rst_n), .issue(issue), .issue_bank(issue_bank),
    .bank_ready(bank_ready));

  vagu_ret_pipe #(.LW(LW), .DW(DW), .LAT(LAT)) u_ret (
    .clk(clk), .rst_n(rst_n), .in_valid(issue), .in_idx(issue_idx),
    .in_data(mem_rdata), .in_last(issue_last), .out_valid(rsp_valid),
    .out_idx(rsp_idx), .out_data(rsp_data), .out_last(ret_last),
    .inflight(inflight));

  assign req_valid = issue;
  assign req_addr  = issue_addr;
  assign req_bank  = issue_bank;
  assign req_idx   = issue_idx;
  assign done      = ret_last || zero_done;

  // R9: requests only appear while the block reports itself busy
  assert_req_when_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> busy);
endmodule

// File: tb/tb_vec_bank_agu.sv
module tb_vec_bank_agu;
  localparam int CLK_PERIOD = 10;
  localparam int LAT  = 12;
  localparam int BUSY = 4;

  logic        clk, rst_n, start;
  logic [31:0] base_addr, stride;
  logic [7:0]  vlen;
  logic        busy, req_valid, rsp_valid, done;
  logic [31:0] req_addr, mem_rdata, rsp_data;
  logic [3:0]  req_bank;
  logic [7:0]  req_idx, rsp_idx;

  vec_bank_agu dut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .stride(stride), .vlen(vlen), .busy(busy), .req_valid(req_valid),
    .req_addr(req_addr), .req_bank(req_bank), .req_idx(req_idx),
    .mem_rdata(mem_rdata), .rsp_valid(rsp_valid), .rsp_idx(rsp_idx),
    .rsp_data(rsp_data), .done(done));

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction
  assign mem_rdata = mem_word(req_addr);

  int checks = 0, failures = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // behavioural reference model
  bit          m_active = 0;
  int          m_idx, m_vlen;
  logic [31:0] m_addr, m_stride;
  int          bank_free [16];
  int          q_due[$], q_idx[$];
  logic [31:0] q_dat[$];
  bit          q_last[$];
  int          zd_due = -1;
  int          req_log[$];
  int          done_cnt = 0, acc_cyc = -1;

  initial begin
    clk = 0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit exp_req, exp_rsp, exp_done, exp_busy;
      cyc++;
      exp_req  = m_active && (bank_free[m_addr[3:0]] <= cyc);
      exp_rsp  = (q_due.size() > 0) && (q_due[0] == cyc);
      exp_done = (exp_rsp && q_last[0]) || (zd_due == cyc);
      exp_busy = m_active || (q_due.size() > 0);
      chk(req_valid == exp_req, "R3", "req_valid", req_valid, exp_req);
      if (exp_req && req_valid) begin
        chk(req_addr == m_addr, "R1", "req_addr", req_addr, m_addr);
        chk(req_idx == 8'(m_idx), "R1", "req_idx", req_idx, m_idx);
        chk(req_bank == req_addr[3:0], "R2", "req_bank", req_bank, req_addr[3:0]);
        req_log.push_back(cyc);
      end
      chk(rsp_valid == exp_rsp, "R6", "rsp_valid", rsp_valid, exp_rsp);
      if (exp_rsp && rsp_valid) begin
        chk(rsp_idx == 8'(q_idx[0]), "R6", "rsp_idx", rsp_idx, q_idx[0]);
        chk(rsp_data == q_dat[0], "R6", "rsp_data", rsp_data, q_dat[0]);
      end
      chk(done == exp_done, "R7", "done", done, exp_done);
      chk(busy == exp_busy, "R9", "busy", busy, exp_busy);
      if (done) done_cnt++;
      // advance model to the next edge
      if (exp_rsp) begin
        void'(q_due.pop_front()); void'(q_idx.pop_front());
        void'(q_dat.pop_front()); void'(q_last.pop_front());
      end
      if (exp_req) begin
        q_due.push_back(cyc + LAT); q_idx.push_back(m_idx);
        q_dat.push_back(mem_word(m_addr)); q_last.push_back(m_idx == m_vlen - 1);
        bank_free[m_addr[3:0]] = cyc + BUSY;
        m_idx++;
        m_addr = m_addr + m_stride;
        if (m_idx == m_vlen) m_active = 0;
      end
      if (start && !exp_busy) begin
        acc_cyc = cyc;
        if (vlen == 0) zd_due = cyc + 1;
        else begin
          m_active = 1; m_idx = 0; m_vlen = int'(vlen);
          m_addr = base_addr; m_stride = stride;
        end
      end
      if (cyc > 100000) begin
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        finished = 1;
        $finish;
      end
    end
  end

  task automatic run_vec(input logic [31:0] b, input logic [31:0] s,
                         input logic [7:0] n, input bit poke_busy);
    req_log.delete();
    done_cnt = 0;
    @(posedge clk); #1;
    start = 1; base_addr = b; stride = s; vlen = n;
    @(posedge clk); #1;
    start = 0;
    if (poke_busy) begin
      @(posedge clk); #1;
      start = 1; vlen = 0; base_addr = 32'hDEAD0000;
      @(posedge clk); #1;
      start = 0;
    end
    repeat (3) @(posedge clk);
    while (busy) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) bank_free[i] = 0;
    rst_n = 0; start = 0; base_addr = 0; stride = 0; vlen = 0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(req_valid == 0, "R10", "req_valid in reset", req_valid, 0);
    chk(rsp_valid == 0, "R10", "rsp_valid in reset", rsp_valid, 0);
    chk(done == 0, "R10", "done in reset", done, 0);
    chk(busy == 0, "R10", "busy in reset", busy, 0);
    @(posedge clk); #1 rst_n = 1;

    // R4 / R9: unit stride, one per cycle from the cycle after start
    run_vec(32'h100, 32'd1, 8'd20, 0);
    chk(req_log.size() == 20, "R1", "unit stride count", req_log.size(), 20);
    chk(req_log[0] == acc_cyc + 1, "R9", "first issue cycle", req_log[0], acc_cyc + 1);
    chk(req_log[19] - req_log[0] == 19, "R4", "unit stride span", req_log[19] - req_log[0], 19);
    chk(done_cnt == 1, "R7", "done pulses", done_cnt, 1);

    // R5: same-bank stride
    run_vec(32'h205, 32'd16, 8'd6, 0);
    chk(req_log.size() == 6, "R5", "stride16 count", req_log.size(), 6);
    for (int i = 1; i < req_log.size(); i++)
      chk(req_log[i] - req_log[i-1] == 4, "R5", "stride16 gap", req_log[i] - req_log[i-1], 4);

    run_vec(32'h0, 32'd48, 8'd4, 0);
    chk(req_log[3] - req_log[0] == 12, "R5", "stride48 span", req_log[3] - req_log[0], 12);

    // R4: two-bank alternation stalls
    run_vec(32'h0, 32'd8, 8'd9, 0);
    chk(req_log[1] - req_log[0] == 1, "R4", "stride8 second", req_log[1] - req_log[0], 1);
    chk(req_log[2] - req_log[0] == 4, "R4", "stride8 third", req_log[2] - req_log[0], 4);

    // R1: negative stride with wrap
    run_vec(32'h3, 32'hFFFF_FFFF, 8'd7, 0);
    chk(req_log.size() == 7, "R1", "negative stride count", req_log.size(), 7);

    // R8: empty vector
    run_vec(32'h77, 32'd1, 8'd0, 0);
    chk(req_log.size() == 0, "R8", "empty vector requests", req_log.size(), 0);
    chk(done_cnt == 1, "R8", "empty vector done", done_cnt, 1);

    // R9: start while busy ignored
    run_vec(32'h40, 32'd3, 8'd4, 1);
    chk(req_log.size() == 4, "R9", "requests with busy start", req_log.size(), 4);
    chk(done_cnt == 1, "R9", "done with busy start", done_cnt, 1);

    // long vector, mixed stride
    run_vec(32'h1000, 32'd6, 8'd255, 0);
    chk(req_log.size() == 255, "R1", "long vector count", req_log.size(), 255);
    chk(done_cnt == 1, "R7", "long vector done", done_cnt, 1);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule